// File: doc/BRIEF.md
# Entropy Source Health Monitor

This block sits directly behind one digitized physical noise source. It watches every accepted raw sample and runs four statistical checks on consecutive fixed windows of samples: a run-length check, a mean-deviation check, a minimum-spread (variance) check and a per-symbol occurrence check. If a window breaks any one of these checks, that window fails. When enough failing windows arrive back to back, the monitor raises a sticky error flag. Software or the surrounding controller clears this flag with a dedicated clear input.

Accepted samples are also packed into 32-bit words and delivered downstream through a valid strobe. A configuration bit selects whether word delivery stops while the error flag is set. An enable input switches the whole source off. While the enable is low, samples are neither tested nor packed.

The arithmetic uses integers only. The mean is compared as twice the window sum against the ideal midpoint sum. The spread is compared as the window length times the sum of squares, minus the square of the sum. Both figures are exact and need no division.

Top module: `entropy_health_mon`

## Requirements
- R1: After reset, `err`, `win_done`, `win_fail` and `word_valid` are all low.
- R2: A sample offered while `enable` is low is ignored. It produces no `win_done` and no `word_valid`, and it does not change any later window result, run count or packed word.
- R3: Accepted samples are packed WORD_W/SW per word, with the oldest sample in the least significant bits. `word_valid` pulses for one cycle, in the cycle after the sample that completes a word is accepted.
- R4: Each window holds 2^WL accepted samples. `win_done` pulses in the cycle after the last sample of a window. `win_fail` pulses with it whenever any of the checks in R5 to R8 fails for that window.
- R5: The run length counts consecutive identical accepted samples, with the current sample included. It continues across window boundaries and saturates at its all-ones value. A window fails if any of its samples ends a run longer than `cfg_run_max`.
- R6: Let S be the window sum, N the window length and M = 2^SW. A window fails if |2·S − N·(M−1)| is greater than `cfg_mean_tol`.
- R7: Let Q be the window sum of squares. A window fails if N·Q − S² is below `cfg_var_min`.
- R8: A window fails if the count of any one of the M symbol values is below `cfg_freq_min` or above `cfg_freq_max`.
- R9: A saturating counter counts consecutive failing windows, and a passing window resets it to zero. `err` rises at the end of the failing window that brings this count to `cfg_fail_limit`. A limit of 0 acts as 1.
- R10: `err` stays set until `clear_err` is asserted. `clear_err` clears `err` and the consecutive-failure count at the next edge.
- R11: When `cfg_block` is high and `err` is set in the cycle in which a word completes, that word is dropped and `word_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Source enable; when low, samples are ignored |
| smp_valid | input | 1 | Raw sample strobe |
| smp_data | input | SW | Raw sample value |
| clear_err | input | 1 | Clears the error flag and the failure count |
| cfg_run_max | input | WL+1 | Longest run length that is allowed |
| cfg_mean_tol | input | SW+WL+1 | Allowed deviation of twice the sum from the ideal sum |
| cfg_var_min | input | 2·(SW+WL) | Minimum scaled spread |
| cfg_freq_min | input | WL+1 | Minimum occurrence count per symbol |
| cfg_freq_max | input | WL+1 | Maximum occurrence count per symbol |
| cfg_fail_limit | input | FAIL_W | Consecutive failing windows needed to raise the error |
| cfg_block | input | 1 | Drop words while the error is set |
| err | output | 1 | Sticky health error |
| win_done | output | 1 | Window-complete pulse |
| win_fail | output | 1 | Window-failed pulse |
| word_valid | output | 1 | Packed word strobe |
| word_data | output | WORD_W | Packed word |

## Verification
The hardest thing to reach from the ports is a window that fails exactly one check while the other three pass. On top of that, the failure-count, sticky-error and blocking paths must be in a known state when it happens. The bench uses a small configuration with 4-bit samples and 32-sample windows. It sweeps six sample patterns across five threshold sets, and in each set only one check is tight, with its threshold stepped so that the same pattern lands on both sides of the limit. Disabled samples are inserted in the middle of windows. A dedicated sequence of failing and passing windows then walks the failure counter up to the limit, through a reset and into blocking and clearing.

// File: rtl/entropy_health_mon.sv
`timescale 1ns/1ps
module entropy_health_mon #(
  parameter int SW     = 8,
  parameter int WL     = 8,
  parameter int WORD_W = 32,
  parameter int FAIL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     smp_valid,
  input  logic [SW-1:0]            smp_data,
  input  logic                     clear_err,
  input  logic [WL:0]              cfg_run_max,
  input  logic [SW+WL:0]           cfg_mean_tol,
  input  logic [2*(SW+WL)-1:0]     cfg_var_min,
  input  logic [WL:0]              cfg_freq_min,
  input  logic [WL:0]              cfg_freq_max,
  input  logic [FAIL_W-1:0]        cfg_fail_limit,
  input  logic                     cfg_block,
  output logic                     err,
  output logic                     win_done,
  output logic                     win_fail,
  output logic                     word_valid,
  output logic [WORD_W-1:0]        word_data
);
  localparam int N     = 1 << WL;
  localparam int M     = 1 << SW;
  localparam int PER   = WORD_W / SW;
  localparam int PK_W  = (PER > 2) ? $clog2(PER) : 1;
  localparam int SUM_W = SW + WL;
  localparam int SQ_W  = 2 * SW + WL;
  localparam int VAR_W = 2 * SUM_W;
  localparam logic [SUM_W:0] MID2 = (SUM_W+1)'((M - 1) * N);

  wire take = enable & smp_valid;

  logic [WL-1:0] win_cnt;
  wire last = &win_cnt;

  // run length
  logic [SW-1:0] prev;
  logic          have_prev;
  logic [WL:0]   run, run_nx;
  logic          run_bad;
  wire same = have_prev && (smp_data == prev);
  assign run_nx = !same ? (WL+1)'(1) : (&run ? run : run + 1'b1);
  wire run_hit = run_nx > cfg_run_max;

  // moments
  logic [SUM_W-1:0] sum;
  logic [SQ_W-1:0]  sq;
  wire [SUM_W-1:0] sum_nx = sum + SUM_W'(smp_data);
  wire [SQ_W-1:0]  sq_nx  = sq + SQ_W'(smp_data) * SQ_W'(smp_data);
  wire [VAR_W-1:0] spread = {sq_nx, {WL{1'b0}}} - VAR_W'(sum_nx) * VAR_W'(sum_nx);
  wire [SUM_W:0]   two_sum = {sum_nx, 1'b0};
  wire [SUM_W:0]   mdev = (two_sum >= MID2) ? two_sum - MID2 : MID2 - two_sum;
  wire mean_bad = mdev > cfg_mean_tol;
  wire var_bad  = spread < cfg_var_min;

  // symbol counts
  logic [WL:0]  fcnt [M];
  logic [WL:0]  fnx  [M];
  logic [M-1:0] fbad;
  for (genvar g = 0; g < M; g++) begin : g_sym
    assign fnx[g]  = fcnt[g] + {{WL{1'b0}}, smp_data == SW'(g)};
    assign fbad[g] = (fnx[g] < cfg_freq_min) || (fnx[g] > cfg_freq_max);
  end
  wire freq_bad = |fbad;

  wire fail_now = run_bad | run_hit | mean_bad | var_bad | freq_bad;

  // failure accounting
  logic [FAIL_W-1:0] consec;
  wire [FAIL_W-1:0] lim    = (cfg_fail_limit == '0) ? FAIL_W'(1) : cfg_fail_limit;
  wire [FAIL_W-1:0] cnt_nx = &consec ? consec : consec + 1'b1;

  // packing
  logic [WORD_W-1:0] sr;
  logic [PK_W-1:0]   pk_cnt;
  wire pk_done = pk_cnt == PK_W'(PER - 1);
  wire [WORD_W-1:0] sr_nx = {smp_data, sr[WORD_W-1:SW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      run       <= '0;
      run_bad   <= 1'b0;
      sum       <= '0;
      sq        <= '0;
      for (int v = 0; v < M; v++) fcnt[v] <= '0;
      win_done  <= 1'b0;
      win_fail  <= 1'b0;
    end else begin
      win_done <= take && last;
      win_fail <= take && last && fail_now;
      if (take) begin
        win_cnt   <= win_cnt + 1'b1;
        prev      <= smp_data;
        have_prev <= 1'b1;
        run       <= run_nx;
        run_bad   <= last ? 1'b0 : (run_bad | run_hit);
        sum       <= last ? '0 : sum_nx;
        sq        <= last ? '0 : sq_nx;
        for (int v = 0; v < M; v++) fcnt[v] <= last ? '0 : fnx[v];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      consec <= '0;
      err    <= 1'b0;
    end else if (clear_err) begin
      consec <= '0;
      err    <= 1'b0;
    end else if (take && last) begin
      if (fail_now) begin
        consec <= cnt_nx;
        if (cnt_nx >= lim) err <= 1'b1;
      end else begin
        consec <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      pk_cnt     <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= take && pk_done && !(cfg_block && err);
      if (take) begin
        sr     <= sr_nx;
        pk_cnt <= pk_done ? '0 : pk_cnt + 1'b1;
        if (pk_done) word_data <= sr_nx;
      end
    end
  end

  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!win_done && !word_valid));
  p_fail_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_fail |-> win_done);
  p_rise_on_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> win_fail);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear_err) |=> err);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_err |=> !err);
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !$past(cfg_block && err));
endmodule

// File: tb/entropy_health_mon_tb.sv
`timescale 1ns/1ps
module entropy_health_mon_tb;
  localparam int SW = 4, WL = 5, WORD_W = 32, FAIL_W = 4;
  localparam int N = 32, M = 16;

  logic clk = 0, rst_n = 0;
  logic enable = 1, smp_valid = 0, clear_err = 0, cfg_block = 0;
  logic [SW-1:0] smp_data = 0;
  logic [WL:0] cfg_run_max = 62, cfg_freq_min = 0, cfg_freq_max = 32;
  logic [SW+WL:0] cfg_mean_tol = 1023;
  logic [2*(SW+WL)-1:0] cfg_var_min = 0;
  logic [FAIL_W-1:0] cfg_fail_limit = 1;
  logic err, win_done, win_fail, word_valid;
  logic [WORD_W-1:0] word_data;

  entropy_health_mon #(.SW(SW), .WL(WL), .WORD_W(WORD_W), .FAIL_W(FAIL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
    .smp_data(smp_data), .clear_err(clear_err), .cfg_run_max(cfg_run_max),
    .cfg_mean_tol(cfg_mean_tol), .cfg_var_min(cfg_var_min),
    .cfg_freq_min(cfg_freq_min), .cfg_freq_max(cfg_freq_max),
    .cfg_fail_limit(cfg_fail_limit), .cfg_block(cfg_block), .err(err),
    .win_done(win_done), .win_fail(win_fail), .word_valid(word_valid),
    .word_data(word_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R4";

  // reference model state
  int fsum = 0, fsq = 0, widx = 0, run = 0, prev = 0, have_prev = 0;
  int runbad = 0, consec = 0, errm = 0, pkn = 0;
  int fc[M];
  logic [31:0] pk = 0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic push(input int v);
    int errb, exp_done, exp_fail, exp_wv, pk_end, lim, two, dev, spread, fb;
    errb = errm; exp_done = 0; exp_fail = 0; exp_wv = 0; pk_end = 0;
    smp_data = SW'(v); smp_valid = 1; enable = 1;
    if (have_prev != 0 && v == prev) run++; else run = 1;
    have_prev = 1; prev = v;
    if (run > int'(cfg_run_max)) runbad = 1;
    fsum += v; fsq += v * v; fc[v]++; widx++;
    pk = (pk >> SW) | (32'(v) << (WORD_W - SW)); pkn++;
    if (pkn == WORD_W / SW) begin
      pkn = 0; pk_end = 1;
      exp_wv = (cfg_block && errb != 0) ? 0 : 1;
    end
    if (widx == N) begin
      exp_done = 1;
      two = 2 * fsum; dev = two - N * (M - 1); if (dev < 0) dev = -dev;
      spread = N * fsq - fsum * fsum;
      fb = 0;
      for (int s = 0; s < M; s++)
        if (fc[s] < int'(cfg_freq_min) || fc[s] > int'(cfg_freq_max)) fb = 1;
      exp_fail = (runbad != 0 || dev > int'(cfg_mean_tol) ||
                  spread < int'(cfg_var_min) || fb != 0) ? 1 : 0;
      lim = (cfg_fail_limit == 0) ? 1 : int'(cfg_fail_limit);
      if (exp_fail != 0) begin
        if (consec < 15) consec++;
        if (consec >= lim) errm = 1;
      end else consec = 0;
      widx = 0; fsum = 0; fsq = 0; runbad = 0;
      for (int s = 0; s < M; s++) fc[s] = 0;
    end
    @(negedge clk);
    smp_valid = 0;
    chk("R4", 32'(win_done), 32'(exp_done));
    if (exp_done != 0) chk(tag, 32'(win_fail), 32'(exp_fail));
    chk((pk_end != 0 && cfg_block && errb != 0) ? "R11" : "R3", 32'(word_valid), 32'(exp_wv));
    if (exp_wv != 0) chk("R3", word_data, pk);
    chk("R9", 32'(err), 32'(errm));
  endtask

  task automatic push_off(input int v);
    smp_data = SW'(v); smp_valid = 1; enable = 0;
    @(negedge clk);
    smp_valid = 0; enable = 1;
    chk("R2", 32'(win_done), 0);
    chk("R2", 32'(word_valid), 0);
  endtask

  task automatic do_clear();
    clear_err = 1;
    @(negedge clk);
    clear_err = 0;
    errm = 0; consec = 0;
    chk("R10", 32'(err), 0);
  endtask

  function automatic int pat(input int k, input int s, input int i);
    case (k)
      0: return i % 16;
      1: return s % 16 + 3;
      2: return (i * i + s) % 16;
      3: return (i / (1 + s % 4)) % 16;
      4: return 8 + (i % 8);
      default: return (i < 16) ? 0 : 15;
    endcase
  endfunction

  task automatic window(input int k, input int s);
    for (int i = 0; i < N; i++) begin
      if (i == 10 && (s % 2) == 1)
        for (int j = 0; j < 3; j++) push_off(15 - j);
      push(pat(k, s, i));
    end
  endtask

  task automatic loose();
    cfg_run_max = 62; cfg_mean_tol = 1023; cfg_var_min = 0;
    cfg_freq_min = 0; cfg_freq_max = 32;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < M; s++) fc[s] = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", 32'(err), 0); chk("R1", 32'(win_done), 0);
    chk("R1", 32'(win_fail), 0); chk("R1", 32'(word_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(err), 0); chk("R1", 32'(word_valid), 0);

    for (int set = 0; set < 5; set++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 6; k++) begin
          loose();
          cfg_block = s[0];
          cfg_fail_limit = (s == 3) ? 4'd0 : FAIL_W'(1 + s % 2);
          case (set)
            0: tag = "R4";
            1: begin tag = "R5"; cfg_run_max = (WL+1)'(1 + s); end
            2: begin tag = "R6"; cfg_mean_tol = (SW+WL+1)'(8 * s); end
            3: begin tag = "R7"; cfg_var_min = 18'(4000 * s + 2000); end
            default: begin tag = "R8"; cfg_freq_min = (WL+1)'(s % 2); cfg_freq_max = (WL+1)'(2 + s); end
          endcase
          window(k, s);
        end
        do_clear();
      end
    end

    // consecutive-failure accounting and blocking
    loose(); tag = "R9"; cfg_run_max = 2; cfg_fail_limit = 3; cfg_block = 1;
    do_clear();
    window(1, 0); window(1, 0); window(0, 0);
    window(1, 0); window(1, 0);
    chk("R9", 32'(err), 0);
    window(1, 0);
    chk("R9", 32'(err), 1);
    tag = "R11";
    window(0, 1);
    do_clear();
    chk("R10", 32'(err), 0);
    window(0, 2);
    window(1, 1);
    chk("R10", 32'(err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule